// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block services one transmit ring of 8-byte buffer descriptors kept in system memory. A kick pulse starts a single pass over the ring. The pass begins at a software-supplied pointer and follows the descriptors until the next address comes back to the ring base. Each ready descriptor's data buffer is read byte by byte into an internal frame store. When a descriptor marked as the end of a frame is reached, the frame is padded if that was requested. An optional 8-byte offload header at the front is removed, and the frame is streamed out on a byte-wide valid/ready channel. Every processed descriptor has its status bits cleared and is written back.

Per-buffer and per-frame events collect in a two-bit event register that software clears by writing ones. A mask selects which events drive the interrupt line. When the pass ends, the ring pointer returns to the base and a halt flag is raised in a 32-bit status word. A partly gathered frame is kept across passes, so a frame may span the wrap point.

Top module: `tx_ring_walker`

## Requirements
- R1: A descriptor is two 32-bit words. The word at offset 0 holds flags and length, and the word at offset 4 holds the buffer pointer. Byte lane k of a memory word is the byte at address+k. With `le_mode`=0 the fields are big-endian: flags high byte at +0, length high byte at +2, pointer most significant byte at +4. With `le_mode`=1 each field is little-endian. The write-back uses the same order.
- R2: While `tx_en` is low, a kick starts nothing: no memory request is issued and the halt bit stays clear.
- R3: A descriptor without the ready flag (0x8000) is neither changed nor written. A ready descriptor with zero length is also left unchanged, adds no bytes and raises no event.
- R4: After each descriptor, the next address is the ring base if the wrap flag (0x2000) is set, and the current address plus 8 otherwise. The pass ends when the next address equals the base. The low 3 bits of the base and of the start pointer are ignored, and `addr_hi` drives address bits 35:32 of every request.
- R5: The buffers from a frame's first descriptor to its last-in-frame descriptor (flag 0x0800) are sent in order as one frame. This holds across passes. Output begins only after the last buffer is gathered, and `tx_last` marks the final byte.
- R6: If the first descriptor of a frame has the pad flag (0x4000), or `pad_all` is high, zero bytes are appended until the gathered frame is 64 bytes. The count includes any offload header.
- R7: If the first descriptor of a frame has the offload flag (0x0002), the first 8 gathered bytes are not sent.
- R8: The written-back flags equal the read flags ANDed with 0x7D00, which clears ready, defer, late collision, retry limit, retry count, underrun and truncation. The length is written back unchanged.
- R9: A written-back descriptor with the interrupt flag (0x1000) sets `evt[1]` if it is last-in-frame and `evt[0]` otherwise. `irq` is high exactly when some set event bit has its `irq_mask` bit set. A one on `evt_clr[i]` clears `evt[i]`.
- R10: At the end of a pass `ring_ptr` equals the aligned base and `halt_status` bit (31 − RING_ID) is set. A kick that starts a pass clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 1 | Start-of-pass pulse |
| tx_en | input | 1 | Transmit enable; a pass starts only when high |
| le_mode | input | 1 | 1 = little-endian descriptor fields |
| pad_all | input | 1 | Pad every frame to 64 bytes |
| ring_base | input | 32 | Ring base address (low 3 bits ignored) |
| start_ptr | input | 32 | First descriptor of the pass (low 3 bits ignored) |
| addr_hi | input | 4 | Address bits 35:32 |
| irq_mask | input | 2 | Event enables for `irq` |
| evt_clr | input | 2 | Write-one-to-clear for `evt` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = word write |
| mem_addr | output | 36 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completion |
| tx_valid | output | 1 | Frame byte valid |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| evt | output | 2 | Event register: bit 0 buffer, bit 1 frame |
| irq | output | 1 | Masked event interrupt |
| ring_ptr | output | 32 | Ring pointer register |
| halt_status | output | 32 | Status word with the halt bit |

## Verification
The hardest situation to reach is a frame whose first buffer sits at the end of the ring while its last buffer sits at the base. The first pass must stop at the wrap with the partial frame kept, and a second pass must complete it. The bench builds such a ring with an unaligned start pointer, a non-ready descriptor and a ready zero-length descriptor in front of the split frame. It checks after each pass that nothing was sent early, that the skipped entries kept their memory image, and that the bytes of both buffers come out as one frame. Backpressure is applied throughout by dropping `tx_ready` one cycle in four.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;

    localparam int EVT_W = 2;

    localparam logic [15:0] FL_READY   = 16'h8000;
    localparam logic [15:0] FL_PAD     = 16'h4000;
    localparam logic [15:0] FL_WRAP    = 16'h2000;
    localparam logic [15:0] FL_INT     = 16'h1000;
    localparam logic [15:0] FL_LAST    = 16'h0800;
    localparam logic [15:0] FL_OFFLOAD = 16'h0002;
    localparam logic [15:0] FL_KEEP    = 16'h7D00;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] len;
    } desc_head_t;

    typedef enum logic [3:0] {
        W_IDLE, W_HEAD, W_PTR, W_CHECK, W_FETCH,
        W_PAD, W_SEND, W_WBACK, W_NEXT, W_DONE
    } walk_state_t;

    function automatic desc_head_t unpack_head(logic [31:0] w, logic le);
        desc_head_t h;
        if (le) begin
            h.flags = w[15:0];
            h.len   = w[31:16];
        end else begin
            h.flags = {w[7:0], w[15:8]};
            h.len   = {w[23:16], w[31:24]};
        end
        return h;
    endfunction

    function automatic logic [31:0] pack_head(desc_head_t h, logic le);
        if (le) return {h.len, h.flags};
        return {h.len[7:0], h.len[15:8], h.flags[7:0], h.flags[15:8]};
    endfunction

    function automatic logic [31:0] unpack_ptr(logic [31:0] w, logic le);
        if (le) return w;
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/tx_evt_unit.sv
module tx_evt_unit
    import tx_ring_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_buf,
    input  logic             set_frame,
    input  logic [EVT_W-1:0] clr,
    input  logic [EVT_W-1:0] mask,
    output logic [EVT_W-1:0] evt,
    output logic             irq
);
    logic [EVT_W-1:0] evt_q;
    logic [EVT_W-1:0] set_vec;

    assign set_vec = {set_frame, set_buf};

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= (evt_q & ~clr) | set_vec;
    end

    assign evt = evt_q;
    assign irq = |(evt_q & mask);

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr[1] && !set_frame) |=> !evt[1]);
    assert_set_R9: assert property (@(posedge clk) disable iff (rst)
        set_buf |=> evt[0]);

endmodule

// File: rtl/tx_frame_buf.sv
module tx_frame_buf #(
    parameter int DEPTH = 2048,
    parameter int STRIP = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          start,
    input  logic          strip,
    output logic [CW-1:0] count,
    output logic          busy,
    output logic          out_valid,
    output logic [7:0]    out_data,
    output logic          out_last,
    input  logic          out_ready
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] SKIP = CW'(STRIP);

    logic [7:0]    store [DEPTH];
    logic [CW-1:0] wr_cnt;
    logic [CW-1:0] rd_idx;
    logic          sending;
    logic [CW-1:0] first_idx;

    assign first_idx = strip ? SKIP : '0;

    always_ff @(posedge clk) begin
        if (push && wr_cnt < FULL) store[wr_cnt[AW-1:0]] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_cnt  <= '0;
            rd_idx  <= '0;
            sending <= 1'b0;
        end else if (sending) begin
            if (out_ready) begin
                if (rd_idx == wr_cnt - 1'b1) begin
                    sending <= 1'b0;
                    wr_cnt  <= '0;
                    rd_idx  <= '0;
                end else begin
                    rd_idx <= rd_idx + 1'b1;
                end
            end
        end else if (start) begin
            if (wr_cnt > first_idx) begin
                sending <= 1'b1;
                rd_idx  <= first_idx;
            end else begin
                wr_cnt <= '0;
            end
        end else if (push && wr_cnt < FULL) begin
            wr_cnt <= wr_cnt + 1'b1;
        end
    end

    assign count     = wr_cnt;
    assign busy      = sending;
    assign out_valid = sending;
    assign out_data  = store[rd_idx[AW-1:0]];
    assign out_last  = sending && (rd_idx == wr_cnt - 1'b1);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        push |-> wr_cnt < FULL);
    assert_out_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/tx_ring_walker.sv
module tx_ring_walker
    import tx_ring_pkg::*;
#(
    parameter int RING_ID     = 0,
    parameter int FIFO_DEPTH  = 2048,
    parameter int PAD_MIN     = 64,
    parameter int STRIP_BYTES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        kick,
    input  logic        tx_en,
    input  logic        le_mode,
    input  logic        pad_all,
    input  logic [31:0] ring_base,
    input  logic [31:0] start_ptr,
    input  logic [3:0]  addr_hi,
    input  logic [1:0]  irq_mask,
    input  logic [1:0]  evt_clr,
    output logic        mem_req,
    output logic        mem_we,
    output logic [35:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic [1:0]  evt,
    output logic        irq,
    output logic [31:0] ring_ptr,
    output logic [31:0] halt_status
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);
    localparam logic [CW-1:0] PAD_LIM  = CW'(PAD_MIN);
    localparam logic [CW-1:0] FIFO_LIM = CW'(FIFO_DEPTH);
    localparam logic [31:0]   HALT_BIT = 32'h8000_0000 >> RING_ID;

    walk_state_t   state;
    logic [31:0]   cur;
    logic [31:0]   base;
    logic [31:0]   nxt;
    desc_head_t    head;
    desc_head_t    wb_head;
    logic [31:0]   bptr;
    logic [15:0]   first_flags;
    logic [15:0]   byte_idx;
    logic [31:0]   byte_addr;
    logic [31:0]   ptr_q;
    logic          halt_q;

    logic          fb_push;
    logic [7:0]    fb_data;
    logic          fb_start;
    logic [CW-1:0] fb_count;
    logic          fb_busy;
    logic          pad_req;
    logic          set_buf;
    logic          set_frame;

    assign base      = {ring_base[31:3], 3'b000};
    assign nxt       = (head.flags & FL_WRAP) != 0 ? base : cur + 32'd8;
    assign byte_addr = bptr + {16'h0, byte_idx};
    assign pad_req   = ((first_flags & FL_PAD) != 0) || pad_all;
    assign wb_head   = '{flags: head.flags & FL_KEEP, len: head.len};

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {addr_hi, cur};
        mem_wdata = '0;
        unique case (state)
            W_HEAD:  mem_req = 1'b1;
            W_PTR: begin
                mem_req  = 1'b1;
                mem_addr = {addr_hi, cur + 32'd4};
            end
            W_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = {addr_hi, byte_addr[31:2], 2'b00};
            end
            W_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = pack_head(wb_head, le_mode);
            end
            default: ;
        endcase
    end

    always_comb begin
        fb_push  = 1'b0;
        fb_data  = mem_rdata[8*byte_addr[1:0] +: 8];
        fb_start = 1'b0;
        if (state == W_FETCH && mem_ack) begin
            fb_push = 1'b1;
        end else if (state == W_PAD) begin
            if (pad_req && fb_count < PAD_LIM && fb_count < FIFO_LIM) begin
                fb_push = 1'b1;
                fb_data = 8'h00;
            end else begin
                fb_start = 1'b1;
            end
        end
    end

    assign set_frame = state == W_WBACK && mem_ack &&
                       (head.flags & FL_INT) != 0 && (head.flags & FL_LAST) != 0;
    assign set_buf   = state == W_WBACK && mem_ack &&
                       (head.flags & FL_INT) != 0 && (head.flags & FL_LAST) == 0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= W_IDLE;
            cur         <= '0;
            head        <= '0;
            bptr        <= '0;
            first_flags <= '0;
            byte_idx    <= '0;
            ptr_q       <= '0;
            halt_q      <= 1'b0;
        end else begin
            unique case (state)
                W_IDLE: if (kick && tx_en) begin
                    cur    <= {start_ptr[31:3], 3'b000};
                    ptr_q  <= {start_ptr[31:3], 3'b000};
                    halt_q <= 1'b0;
                    state  <= W_HEAD;
                end
                W_HEAD: if (mem_ack) begin
                    head  <= unpack_head(mem_rdata, le_mode);
                    state <= W_PTR;
                end
                W_PTR: if (mem_ack) begin
                    bptr     <= unpack_ptr(mem_rdata, le_mode);
                    byte_idx <= '0;
                    state    <= W_CHECK;
                end
                W_CHECK: begin
                    if ((head.flags & FL_READY) == 0 || head.len == 0) begin
                        state <= W_NEXT;
                    end else begin
                        if (fb_count == 0) first_flags <= head.flags;
                        state <= W_FETCH;
                    end
                end
                W_FETCH: if (mem_ack) begin
                    byte_idx <= byte_idx + 1'b1;
                    if (byte_idx == head.len - 1'b1)
                        state <= (head.flags & FL_LAST) != 0 ? W_PAD : W_WBACK;
                end
                W_PAD:  if (fb_start) state <= W_SEND;
                W_SEND: if (!fb_busy) state <= W_WBACK;
                W_WBACK: if (mem_ack) state <= W_NEXT;
                W_NEXT: begin
                    if (nxt == base) begin
                        state <= W_DONE;
                    end else begin
                        cur   <= nxt;
                        state <= W_HEAD;
                    end
                end
                W_DONE: begin
                    ptr_q  <= base;
                    halt_q <= 1'b1;
                    state  <= W_IDLE;
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    assign ring_ptr    = ptr_q;
    assign halt_status = halt_q ? HALT_BIT : 32'h0;

    tx_frame_buf #(
        .DEPTH (FIFO_DEPTH),
        .STRIP (STRIP_BYTES)
    ) u_buf (
        .clk       (clk),
        .rst       (rst),
        .push      (fb_push),
        .push_data (fb_data),
        .start     (fb_start),
        .strip     ((first_flags & FL_OFFLOAD) != 0),
        .count     (fb_count),
        .busy      (fb_busy),
        .out_valid (tx_valid),
        .out_data  (tx_data),
        .out_last  (tx_last),
        .out_ready (tx_ready)
    );

    tx_evt_unit u_evt (
        .clk       (clk),
        .rst       (rst),
        .set_buf   (set_buf),
        .set_frame (set_frame),
        .clr       (evt_clr),
        .mask      (irq_mask),
        .evt       (evt),
        .irq       (irq)
    );

    assert_mem_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (state == W_IDLE && !tx_en) |=> !mem_req);
    assert_send_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !mem_req);
    assert_halt_ptr_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_status[31-RING_ID]) |-> ring_ptr == base);

endmodule

// File: tb/tx_ring_walker_test.sv
module tx_ring_walker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        kick = 1'b0;
    logic        tx_en = 1'b1;
    logic        le_mode = 1'b0;
    logic        pad_all = 1'b0;
    logic [31:0] ring_base = 32'h100;
    logic [31:0] start_ptr = 32'h100;
    logic [3:0]  addr_hi = 4'h5;
    logic [1:0]  irq_mask = 2'b00;
    logic [1:0]  evt_clr = 2'b00;
    logic        mem_req, mem_we, mem_ack;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        tx_valid, tx_last, tx_ready;
    logic [7:0]  tx_data;
    logic [1:0]  evt;
    logic        irq;
    logic [31:0] ring_ptr, halt_status;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    tx_ring_walker uut (
        .clk(clk), .rst(rst), .kick(kick), .tx_en(tx_en), .le_mode(le_mode),
        .pad_all(pad_all), .ring_base(ring_base), .start_ptr(start_ptr),
        .addr_hi(addr_hi), .irq_mask(irq_mask), .evt_clr(evt_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .evt(evt), .irq(irq), .ring_ptr(ring_ptr),
        .halt_status(halt_status)
    );

    // memory model: one word per request, ack one cycle later
    logic [7:0]  mem [4096];
    logic [11:0] wa;
    int          req_seen = 0;
    int          hi_err = 0;
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req) req_seen <= req_seen + 1;
            if (mem_req && mem_addr[35:32] != addr_hi) hi_err <= hi_err + 1;
            if (mem_req && !mem_ack) begin
                wa = {mem_addr[11:2], 2'b00};
                if (mem_we) begin
                    mem[wa]   <= mem_wdata[7:0];
                    mem[wa+1] <= mem_wdata[15:8];
                    mem[wa+2] <= mem_wdata[23:16];
                    mem[wa+3] <= mem_wdata[31:24];
                end
                mem_rdata <= {mem[wa+3], mem[wa+2], mem[wa+1], mem[wa]};
            end
        end
    end

    logic [7:0] rdy_cnt = 8'h0;
    always @(posedge clk) rdy_cnt <= rdy_cnt + 1'b1;
    assign tx_ready = rdy_cnt[1:0] != 2'b11;

    // output collector, sampled away from the active edge
    logic [7:0] rx_buf [2048];
    int rx_cnt = 0;
    int rx_frames = 0;
    int last_at = -1;
    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            rx_buf[rx_cnt] <= tx_data;
            if (tx_last) begin
                last_at   <= rx_cnt;
                rx_frames <= rx_frames + 1;
            end
            rx_cnt <= rx_cnt + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            n_run  = n_run + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] pat(int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run = n_run + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic put_desc(input int a, input logic [15:0] fl, input logic [15:0] ln,
                            input logic [31:0] p, input logic le);
        if (le) begin
            mem[a] = fl[7:0];  mem[a+1] = fl[15:8];
            mem[a+2] = ln[7:0]; mem[a+3] = ln[15:8];
            mem[a+4] = p[7:0];  mem[a+5] = p[15:8]; mem[a+6] = p[23:16]; mem[a+7] = p[31:24];
        end else begin
            mem[a] = fl[15:8]; mem[a+1] = fl[7:0];
            mem[a+2] = ln[15:8]; mem[a+3] = ln[7:0];
            mem[a+4] = p[31:24]; mem[a+5] = p[23:16]; mem[a+6] = p[15:8]; mem[a+7] = p[7:0];
        end
    endtask

    function automatic logic [15:0] get_flags(input int a, input logic le);
        return le ? {mem[a+1], mem[a]} : {mem[a], mem[a+1]};
    endfunction

    function automatic logic [15:0] get_len(input int a, input logic le);
        return le ? {mem[a+3], mem[a+2]} : {mem[a+2], mem[a+3]};
    endfunction

    task automatic run_walk();
        @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            if (halt_status[31]) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk);
        evt_clr = 2'b11;
        @(negedge clk);
        evt_clr = 2'b00;
        rx_cnt = 0;
        last_at = -1;
    endtask

    // {flags, length, little-endian, pad_all, expected output length}
    localparam logic [47:0] VEC [6] = '{
        {16'hB800, 16'd70, 4'h0, 4'h0, 8'd70},
        {16'hE800, 16'd20, 4'h0, 4'h0, 8'd64},
        {16'hA802, 16'd30, 4'h1, 4'h0, 8'd22},
        {16'hF802, 16'd10, 4'h1, 4'h0, 8'd56},
        {16'hA800, 16'd5,  4'h1, 4'h1, 8'd64},
        {16'hAEFD, 16'd3,  4'h0, 4'h0, 8'd3}
    };

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = pat(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        check(!tx_valid && !mem_req, "R5 reset idle", {tx_valid, mem_req}, 0);
        check(evt == 0 && !irq, "R9 reset events", {evt, irq}, 0);
        check(halt_status == 0 && ring_ptr == 0, "R10 reset status", halt_status, 0);

        // vector table: single-descriptor frames
        for (int v = 0; v < 6; v++) begin
            logic [15:0] fl;
            logic [15:0] ln;
            logic        le;
            int          exp_len;
            int          bad;
            int          off;
            fl      = VEC[v][47:32];
            ln      = VEC[v][31:16];
            le      = VEC[v][12];
            exp_len = int'(VEC[v][7:0]);
            clear_all();
            le_mode = le;
            pad_all = VEC[v][8];
            ring_base = 32'h100;
            start_ptr = 32'h100;
            put_desc(32'h100, fl, ln, 32'h400, le);
            run_walk();
            check(rx_cnt == exp_len, "R6/R7 frame length", rx_cnt, exp_len);
            check(last_at == exp_len - 1, "R5 last marker", last_at, exp_len - 1);
            bad = 0;
            off = fl[1] ? 8 : 0;
            for (int j = 0; j < exp_len; j++) begin
                logic [7:0] e;
                e = (j + off < int'(ln)) ? pat(32'h400 + j + off) : 8'h00;
                if (rx_buf[j] !== e) bad++;
            end
            check(bad == 0, "R1/R6 frame bytes", bad, 0);
            check(get_flags(32'h100, le) == (fl & 16'h7D00), "R8 write-back flags",
                  get_flags(32'h100, le), fl & 16'h7D00);
            check(get_len(32'h100, le) == ln, "R8 length kept", get_len(32'h100, le), ln);
            check(evt == (fl[12] ? 2'b10 : 2'b00), "R9 frame event", evt, fl[12] ? 2 : 0);
            check(halt_status == 32'h8000_0000 && ring_ptr == 32'h100, "R10 halt",
                  halt_status, 32'h8000_0000);
        end

        // disabled transmitter
        clear_all();
        tx_en = 1'b0;
        put_desc(32'h100, 16'hA800, 16'd4, 32'h400, 1'b0);
        @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        req_seen = 0;
        repeat (60) @(negedge clk);
        check(req_seen == 0, "R2 no memory traffic", req_seen, 0);
        check(get_flags(32'h100, 1'b0) == 16'hA800, "R2 descriptor untouched",
              get_flags(32'h100, 1'b0), 16'hA800);
        tx_en = 1'b1;

        // frame split across the wrap, with skipped entries
        clear_all();
        le_mode = 1'b0;
        pad_all = 1'b0;
        ring_base = 32'h105;
        start_ptr = 32'h10B;
        put_desc(32'h100, 16'h9800, 16'd15, 32'h500, 1'b0);
        put_desc(32'h108, 16'h0000, 16'd4,  32'h400, 1'b0);
        put_desc(32'h110, 16'h8000, 16'd0,  32'h400, 1'b0);
        put_desc(32'h118, 16'hB000, 16'd12, 32'h400, 1'b0);
        run_walk();
        check(rx_cnt == 0, "R5 no output before last buffer", rx_cnt, 0);
        check(evt == 2'b01, "R9 buffer event", evt, 1);
        check(get_flags(32'h108, 1'b0) == 16'h0000, "R3 not-ready unchanged",
              get_flags(32'h108, 1'b0), 0);
        check(get_flags(32'h110, 1'b0) == 16'h8000, "R3 zero-length unchanged",
              get_flags(32'h110, 1'b0), 16'h8000);
        check(get_flags(32'h118, 1'b0) == 16'h3000, "R8 wrap entry written",
              get_flags(32'h118, 1'b0), 16'h3000);
        check(ring_ptr == 32'h100 && halt_status[31], "R4 wrap ends pass at base",
              ring_ptr, 32'h100);
        start_ptr = 32'h100;
        run_walk();
        check(rx_cnt == 27 && rx_frames > 0, "R5 joined frame length", rx_cnt, 27);
        begin
            int bad2;
            bad2 = 0;
            for (int j = 0; j < 27; j++) begin
                logic [7:0] e;
                e = (j < 12) ? pat(32'h400 + j) : pat(32'h500 + j - 12);
                if (rx_buf[j] !== e) bad2++;
            end
            check(bad2 == 0, "R5 joined frame bytes", bad2, 0);
        end
        check(last_at == 26, "R5 joined last marker", last_at, 26);
        check(get_flags(32'h100, 1'b0) == 16'h1800, "R8 base entry written",
              get_flags(32'h100, 1'b0), 16'h1800);
        check(evt == 2'b11, "R9 both events", evt, 3);
        check(hi_err == 0, "R4 high address bits", hi_err, 0);

        // interrupt masking and write-one-to-clear
        irq_mask = 2'b00;
        @(negedge clk);
        check(!irq, "R9 all masked", irq, 0);
        irq_mask = 2'b10;
        @(negedge clk);
        check(irq, "R9 frame unmasked", irq, 1);
        evt_clr = 2'b10;
        @(negedge clk);
        evt_clr = 2'b00;
        @(negedge clk);
        check(evt == 2'b01 && !irq, "R9 frame cleared", {evt, irq}, 2);
        irq_mask = 2'b01;
        @(negedge clk);
        check(irq, "R9 buffer unmasked", irq, 1);
        evt_clr = 2'b01;
        @(negedge clk);
        evt_clr = 2'b00;
        @(negedge clk);
        check(evt == 2'b00 && !irq, "R9 all cleared", {evt, irq}, 0);

        // a new pass clears the halt bit
        @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        @(negedge clk);
        check(halt_status == 0, "R10 kick clears halt", halt_status, 0);
        repeat (200) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule